// File: doc/BRIEF.md
# Input Combiner and Sample-Rate Strobe

This block sits at the head of a feedback-controller datapath. On every clock it receives two signed converter samples: the measured signal and a reference. It combines them in one of four ways set by the host: measured only, reference only, zero, or the sum of the two. It widens the result to the filter word width. A programmable divider produces a one-clock sample strobe, so the downstream filter runs at a fraction of the converter rate. The combined sample is registered together with that strobe.

The host can rewrite the combining mode and the divide ratio while the block is running. A new value takes effect only at the next strobe. This keeps the filter from seeing a half-switched sample and keeps the strobe period from being cut short. A second output gives a full-rate tap of the combined value for data acquisition.

Top module: `sample_combiner`

## Requirements
- R1: The 2-bit mode selects the combination. Code 0 gives zero, 1 gives the measured input, 2 gives the reference input, and 3 gives measured plus reference. Bit 0 enables the measured input and bit 1 enables the reference input.
- R2: The combination is formed at one bit more than the input width and is sign-extended to the output width. Two full-scale inputs of the same sign give their exact sum (−2048 + −2048 = −4096) with no wrap.
- R3: With an active divide ratio N ≥ 2, `sampleStrobe` is high for exactly one clock in every N clocks.
- R4: A divide ratio of 0 or 1 gives a strobe on every clock.
- R5: A divide-ratio write takes effect at the next strobe. The period that is running when the write happens completes at its old length, and every period after that strobe has the new length.
- R6: `sampleOut` changes only in a cycle where `sampleStrobe` is high. It holds the inputs combined under the mode that was pending at that strobe. A mode write changes nothing until the next strobe.
- R7: `tapOut` updates on every clock with the inputs combined under the mode in force. On a strobe cycle it equals `sampleOut`.
- R8: During reset `sampleOut` and `tapOut` are zero and `sampleStrobe` is low. The mode resets to zero and the divide ratio resets to DEF_DIV (128). The first strobe comes on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| measIn | input | IN_W (12) | Signed measured sample, one per clock |
| refIn | input | IN_W (12) | Signed reference sample, one per clock |
| modeWr | input | 1 | Write enable for the pending mode |
| modeWrData | input | 2 | New mode code (R1 encoding) |
| divWr | input | 1 | Write enable for the pending divide ratio |
| divWrData | input | DIV_W (16) | New divide ratio |
| sampleOut | output | OUT_W (24) | Signed combined sample, registered at each strobe |
| sampleStrobe | output | 1 | One-clock sample enable for the filter |
| tapOut | output | OUT_W (24) | Signed full-rate acquisition tap |

## Verification
The hardest case to reach is a host write that lands in the middle of a strobe period. This must not disturb the period already running, even when a second write replaces the first before the boundary arrives. The stimulus uses short divide ratios (3, 7, 9) so that many boundaries pass. It places divide-ratio writes and mode writes at several offsets inside a period, including two writes in one period. It also switches between ratio 0, 1 and larger ratios back to back. Every clock is compared against a behavioural model that tracks the pending and active settings, so a setting applied one cycle early or late shows up as a strobe or sample mismatch.

// File: rtl/sample_combiner_pkg.sv
package sample_combiner_pkg;

  typedef enum logic [1:0] {
    MODE_ZERO = 2'd0,
    MODE_MEAS = 2'd1,
    MODE_REF  = 2'd2,
    MODE_SUM  = 2'd3
  } combMode_e;

  // Control to datapath: load marks a strobe cycle, mode is the mode to use this cycle
  typedef struct packed {
    logic      load;
    combMode_e mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/sample_combiner_ctrl.sv
module sample_combiner_ctrl
  import sample_combiner_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWr,
  input  logic [1:0]       modeWrData,
  input  logic             divWr,
  input  logic [DIV_W-1:0] divWrData,
  output ctrlStrobe_t      ctl
);

  localparam logic [DIV_W-1:0] DivReset = DIV_W'(DEF_DIV);

  combMode_e        pendMode;
  combMode_e        actMode;
  logic [DIV_W-1:0] pendDiv;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;
  logic             load;

  // Ratios 0 and 1 both mean one clock per sample
  always_comb begin
    reload = (pendDiv < DIV_W'(2)) ? '0 : pendDiv - DIV_W'(1);
    load   = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMode <= MODE_ZERO;
      actMode  <= MODE_ZERO;
      pendDiv  <= DivReset;
      cnt      <= '0;
    end else begin
      if (modeWr) pendMode <= combMode_e'(modeWrData);
      if (divWr)  pendDiv  <= divWrData;
      if (load) begin
        cnt     <= reload;
        actMode <= pendMode;
      end else begin
        cnt <= cnt - DIV_W'(1);
      end
    end
  end

  always_comb begin
    ctl.load = load;
    ctl.mode = load ? pendMode : actMode;
  end

endmodule

// File: rtl/sample_combiner_dp.sv
module sample_combiner_dp
  import sample_combiner_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [IN_W-1:0]  measIn,
  input  logic signed [IN_W-1:0]  refIn,
  input  ctrlStrobe_t             ctl,
  output logic signed [OUT_W-1:0] sampleOut,
  output logic                    sampleStrobe,
  output logic signed [OUT_W-1:0] tapOut
);

  localparam int SumW = IN_W + 1;

  logic [1:0]              modeBits;
  logic signed [SumW-1:0]  measExt;
  logic signed [SumW-1:0]  refExt;
  logic signed [SumW-1:0]  sumNarrow;
  logic signed [OUT_W-1:0] combined;

  always_comb begin
    modeBits  = ctl.mode;
    measExt   = modeBits[0] ? SumW'(measIn) : '0;
    refExt    = modeBits[1] ? SumW'(refIn)  : '0;
    sumNarrow = measExt + refExt;
    combined  = OUT_W'(sumNarrow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut    <= '0;
      sampleStrobe <= 1'b0;
      tapOut       <= '0;
    end else begin
      sampleStrobe <= ctl.load;
      tapOut       <= combined;
      if (ctl.load) sampleOut <= combined;
    end
  end

endmodule

// File: rtl/sample_combiner.sv
module sample_combiner
  import sample_combiner_pkg::*;
#(
  parameter int IN_W    = 12,
  parameter int OUT_W   = 24,
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [IN_W-1:0]  measIn,
  input  logic signed [IN_W-1:0]  refIn,
  input  logic                    modeWr,
  input  logic [1:0]              modeWrData,
  input  logic                    divWr,
  input  logic [DIV_W-1:0]        divWrData,
  output logic signed [OUT_W-1:0] sampleOut,
  output logic                    sampleStrobe,
  output logic signed [OUT_W-1:0] tapOut
);

  ctrlStrobe_t ctl;

  sample_combiner_ctrl #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .modeWr(modeWr), .modeWrData(modeWrData),
    .divWr(divWr), .divWrData(divWrData),
    .ctl(ctl)
  );

  sample_combiner_dp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .measIn(measIn), .refIn(refIn),
    .ctl(ctl),
    .sampleOut(sampleOut), .sampleStrobe(sampleStrobe), .tapOut(tapOut)
  );

endmodule

// File: rtl/sample_combiner_chk.sv
module sample_combiner_chk #(
  parameter int IN_W    = 12,
  parameter int OUT_W   = 24,
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 128
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    divWr,
  input logic [DIV_W-1:0]        divWrData,
  input logic signed [OUT_W-1:0] sampleOut,
  input logic                    sampleStrobe,
  input logic signed [OUT_W-1:0] tapOut
);

  localparam int TopW = OUT_W - IN_W;

  // Divide ratio tracked from the write port, and the cycle gap between strobes
  logic [DIV_W-1:0] seenDiv, seenDivD, needGap;
  logic [DIV_W:0]   gapCnt;
  logic             seenStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenDiv    <= DIV_W'(DEF_DIV);
      seenDivD   <= DIV_W'(DEF_DIV);
      needGap    <= DIV_W'(1);
      gapCnt     <= '0;
      seenStrobe <= 1'b0;
    end else begin
      if (divWr) seenDiv <= divWrData;
      seenDivD <= seenDiv;
      if (sampleStrobe) begin
        // R3 R4 R5: each strobe period equals the ratio pending at the previous strobe
        a_r5_period_len: assert (!seenStrobe || gapCnt == {1'b0, needGap})
          else $error("strobe gap %0d, expected %0d", gapCnt, needGap);
        needGap    <= (seenDivD < DIV_W'(2)) ? DIV_W'(1) : seenDivD;
        gapCnt     <= (DIV_W+1)'(1);
        seenStrobe <= 1'b1;
      end else if (gapCnt != '1) begin
        gapCnt <= gapCnt + (DIV_W+1)'(1);
      end
    end
  end

  a_r7_tap_match: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> (tapOut == sampleOut));

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> (!sampleStrobe |-> 1'b1) and $stable(sampleOut) or $past(sampleStrobe) == 1'b0 && sampleStrobe);

  a_r2_sign_ext: assert property (@(posedge clk) disable iff (!rstN)
    sampleOut[OUT_W-1:IN_W] == {TopW{sampleOut[IN_W]}});

endmodule

bind sample_combiner sample_combiner_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)
) u_chk (
  .clk(clk), .rstN(rstN), .divWr(divWr), .divWrData(divWrData),
  .sampleOut(sampleOut), .sampleStrobe(sampleStrobe), .tapOut(tapOut)
);

// File: tb/sample_combiner_tb.sv
module sample_combiner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 12, OUT_W = 24, DIV_W = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic signed [IN_W-1:0] measIn = '0, refIn = '0;
  logic modeWr = 1'b0, divWr = 1'b0;
  logic [1:0] modeWrData = '0;
  logic [DIV_W-1:0] divWrData = '0;
  logic signed [OUT_W-1:0] sampleOut, tapOut;
  logic sampleStrobe;

  sample_combiner u_dut (
    .clk(clk), .rstN(rstN), .measIn(measIn), .refIn(refIn),
    .modeWr(modeWr), .modeWrData(modeWrData), .divWr(divWr), .divWrData(divWrData),
    .sampleOut(sampleOut), .sampleStrobe(sampleStrobe), .tapOut(tapOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit done = 0, comparing = 0;
  string strobeReq = "R8", sampleReq = "R6";

  // Behavioural model: pending and active settings, countdown to next strobe
  int mCnt, mPendDiv, mPendMode, mActMode, mSample, mTap;
  bit mStrobe;

  function automatic int combineRef(int m, int a, int b);
    return ((m % 2) != 0 ? a : 0) + ((m / 2) != 0 ? b : 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPendDiv = 128; mPendMode = 0; mActMode = 0;
      mSample = 0; mTap = 0; mStrobe = 0;
    end else begin
      if (mCnt == 0) begin
        mStrobe = 1;
        mSample = combineRef(mPendMode, int'(measIn), int'(refIn));
        mTap = mSample;
        mActMode = mPendMode;
        mCnt = (mPendDiv < 2 ? 1 : mPendDiv) - 1;
      end else begin
        mStrobe = 0;
        mTap = combineRef(mActMode, int'(measIn), int'(refIn));
        mCnt = mCnt - 1;
      end
      if (modeWr) mPendMode = int'(modeWrData);
      if (divWr) mPendDiv = int'(divWrData);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (comparing) begin
    check(strobeReq, "sampleStrobe", int'(sampleStrobe), int'(mStrobe));
    check(sampleReq, "sampleOut", int'(sampleOut), mSample);
    check("R7", "tapOut", int'(tapOut), mTap);
  end

  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      modeWr = 0; divWr = 0;
      if (rnd) begin measIn = IN_W'($urandom); refIn = IN_W'($urandom); end
    end
  endtask

  task automatic setMode(int m);
    @(negedge clk); modeWr = 1; modeWrData = 2'(m); divWr = 0;
    measIn = IN_W'($urandom); refIn = IN_W'($urandom);
  endtask

  task automatic setDiv(int d);
    @(negedge clk); divWr = 1; divWrData = DIV_W'(d); modeWr = 0;
    measIn = IN_W'($urandom); refIn = IN_W'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    check("R8", "reset sampleOut", int'(sampleOut), 0);
    check("R8", "reset tapOut", int'(tapOut), 0);
    check("R8", "reset strobe", int'(sampleStrobe), 0);
    rstN = 1; comparing = 1;
    strobeReq = "R3"; sampleReq = "R6";
    run(300, 1);                     // default ratio, mode zero
    setMode(1); run(300, 1);         // R6: measured mode from next strobe
    strobeReq = "R5";
    setDiv(4); run(200, 1);          // R5: mid-period ratio change
    sampleReq = "R1";
    for (int m = 0; m < 4; m++) begin setMode(m); run(13, 1); end
    sampleReq = "R2";
    setDiv(2); setMode(3);
    @(negedge clk); measIn = -12'sd2048; refIn = -12'sd2048; run(6, 0);
    @(negedge clk); measIn = 12'sd2047; refIn = 12'sd2047; run(6, 0);
    @(negedge clk); measIn = -12'sd2048; refIn = 12'sd2047; run(6, 0);
    strobeReq = "R4"; sampleReq = "R6";
    setDiv(0); run(12, 1);
    for (int i = 0; i < 8; i++) setMode(i % 4);
    setDiv(1); run(12, 1);
    for (int i = 0; i < 8; i++) setMode(3 - i % 4);
    strobeReq = "R5";
    setDiv(7); run(3, 1);
    setDiv(3); run(2, 1); setDiv(9); run(40, 1);
    sampleReq = "R6";
    setMode(1); run(2, 1); setMode(2); run(30, 1);
    setDiv(1); run(4, 1); setDiv(5); run(30, 1);
    done = 1;
    comparing = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule